// File: doc/BRIEF.md
# Page Translation Cache

This block is a small, fully associative cache of page translations for a 32-bit virtual address space with 4096-byte pages. The low twelve address bits are the byte offset, which passes through untouched. The upper twenty bits form the virtual page number, which is compared against every stored tag in parallel. A lookup is presented on one cycle, and its outcome appears on the following cycle as exactly one of three results: a translation (hit), no matching entry (miss), or a matching entry whose page is not resident (page fault). The fault result is kept separate from an ordinary miss so that the requester can tell a cold entry from a page that must first be brought in.

After a miss, an external walker writes the missing entry through a refill port. The refill may mark the page as not resident. The refill picks the lowest free slot. When the cache is full, it replaces entries in turn under a rotating pointer. Each resident entry keeps a modified flag that write lookups set. When a valid entry is replaced, its page number, frame number and modified flag are reported for one cycle, so that a write-back pager can save the page. A flush input invalidates every entry in one cycle.

The result path is a four-state machine whose state is the outcome of the previous cycle:
- RS_IDLE: no lookup.
- RS_HIT: translation delivered.
- RS_MISS: no valid tag matched.
- RS_FAULT: the tag matched but the page is absent.

Every cycle the machine moves to a new state, which depends only on the current lookup:
- With no lookup request, it goes to RS_IDLE.
- With no tag match, it goes to RS_MISS.
- With a match on a resident entry, it goes to RS_HIT.
- With a match on a non-resident entry, it goes to RS_FAULT.

Any state can move to any other.

Top module: `tlb_xlat`

## Requirements
- R1: On a hit, res_paddr equals {stored frame number, lk_vaddr[11:0]}, presented in the cycle after the lookup.
- R2: A lookup whose page number (lk_vaddr[31:12]) matches no valid entry gives res_miss=1 and res_paddr=0 one cycle later.
- R3: A lookup that matches an entry filled with fill_present=0 gives res_fault=1, res_hit=0 and res_paddr=0 one cycle later.
- R4: In the cycle after a lookup, exactly one of res_hit, res_miss and res_fault is 1. In the cycle after a cycle without a lookup, all three are 0.
- R5: A write lookup (lk_write=1) that hits sets that entry's modified flag. A write lookup that faults or misses does not set it.
- R6: A refill of a page number not held, while any entry is invalid, uses the lowest-index invalid entry and gives evict_valid=0.
- R7: A refill into a full cache replaces the entry under a rotating pointer. The pointer starts at entry 0 after reset and advances by one, wrapping, on each replacement. One cycle after the refill, evict_valid=1 with the old evict_vpn and evict_ppn.
- R8: evict_dirty carries the replaced entry's modified flag.
- R9: A refill of a page number already held overwrites that entry in place with the new frame and presence, clears its modified flag and gives evict_valid=0.
- R10: flush invalidates all entries in one cycle. A refill in the same cycle as flush is discarded. Lookups after the flush miss.
- R11: After reset, all outputs are 0, all entries are invalid and the rotating pointer is at entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_write | input | 1 | Lookup is a write access |
| lk_vaddr | input | 32 | Virtual address to translate |
| fill_valid | input | 1 | Refill request this cycle |
| fill_vpn | input | 20 | Page number to install |
| fill_ppn | input | 20 | Frame number to install |
| fill_present | input | 1 | 1 if the page is resident |
| flush | input | 1 | Invalidate all entries |
| res_hit | output | 1 | Previous lookup hit |
| res_miss | output | 1 | Previous lookup missed |
| res_fault | output | 1 | Previous lookup hit a non-resident page |
| res_paddr | output | 32 | Translated physical address (0 unless hit) |
| evict_valid | output | 1 | A valid entry was replaced on the previous cycle |
| evict_vpn | output | 20 | Page number of the replaced entry |
| evict_ppn | output | 20 | Frame number of the replaced entry |
| evict_dirty | output | 1 | Modified flag of the replaced entry |

## Verification
Lookup results and eviction reports are each due exactly one rising edge after the cycle in which the request is presented. A refill, a flush or a write-hit flag becomes visible to a lookup presented on the following cycle. The bench drives every request on a falling edge and reads the outputs on the next falling edge, which is after the single register stage. It then drops the request before the next one, so each sample belongs to one stimulus only. The checker states the same one-cycle relation as properties, relating each result to the request of the previous cycle.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    // Outcome of the lookup presented on the previous cycle
    typedef enum logic [1:0] {
        RS_IDLE  = 2'd0,
        RS_HIT   = 2'd1,
        RS_MISS  = 2'd2,
        RS_FAULT = 2'd3
    } res_state_e;

endpackage

// File: rtl/tlb_cam.sv
// Parallel tag compare returning a one-hot match vector and its index
module tlb_cam #(
    parameter int N     = 16,
    parameter int KEY_W = 20,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     valid,
    input  logic [KEY_W-1:0] tags [N],
    input  logic [KEY_W-1:0] key,
    output logic [N-1:0]     match,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = valid[g] && (tags[g] == key);
    end

    assign any = |match;

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) idx = idx | IDX_W'(i);
        end
    end

endmodule

// File: rtl/tlb_victim.sv
// Slot choice for a refill: lowest invalid entry, else rotating pointer
module tlb_victim #(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     valid,
    input  logic             advance,
    output logic [IDX_W-1:0] idx,
    output logic             full
);

    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] free_idx;
    logic             found;

    assign full = &valid;

    always_comb begin
        free_idx = '0;
        found    = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!found && !valid[i]) begin
                free_idx = IDX_W'(i);
                found    = 1'b1;
            end
        end
    end

    assign idx = full ? ptr_q : free_idx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (advance) begin
            ptr_q <= (ptr_q == IDX_W'(N - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

endmodule

// File: rtl/tlb_xlat.sv
module tlb_xlat
    import tlb_pkg::*;
#(
    parameter int VA_W    = 32,
    parameter int OFF_W   = 12,
    parameter int PPN_W   = 20,
    parameter int ENTRIES = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   lk_valid,
    input  logic                   lk_write,
    input  logic [VA_W-1:0]        lk_vaddr,
    input  logic                   fill_valid,
    input  logic [VA_W-OFF_W-1:0]  fill_vpn,
    input  logic [PPN_W-1:0]       fill_ppn,
    input  logic                   fill_present,
    input  logic                   flush,
    output logic                   res_hit,
    output logic                   res_miss,
    output logic                   res_fault,
    output logic [PPN_W+OFF_W-1:0] res_paddr,
    output logic                   evict_valid,
    output logic [VA_W-OFF_W-1:0]  evict_vpn,
    output logic [PPN_W-1:0]       evict_ppn,
    output logic                   evict_dirty
);

    localparam int VPN_W = VA_W - OFF_W;
    localparam int PA_W  = PPN_W + OFF_W;
    localparam int IDX_W = $clog2(ENTRIES);

    // Entry storage
    logic [ENTRIES-1:0] vld_q;
    logic [ENTRIES-1:0] prs_q;
    logic [ENTRIES-1:0] dirty_q;
    logic [VPN_W-1:0]   tag_q [ENTRIES];
    logic [PPN_W-1:0]   frm_q [ENTRIES];

    // Lookup compare
    logic [ENTRIES-1:0] lk_match;
    logic               lk_any;
    logic [IDX_W-1:0]   lk_idx;
    logic [VPN_W-1:0]   lk_vpn;

    assign lk_vpn = lk_vaddr[VA_W-1:OFF_W];

    tlb_cam #(.N(ENTRIES), .KEY_W(VPN_W), .IDX_W(IDX_W)) u_lk_cam (
        .valid (vld_q),
        .tags  (tag_q),
        .key   (lk_vpn),
        .match (lk_match),
        .any   (lk_any),
        .idx   (lk_idx)
    );

    // Refill compare and slot choice
    logic [ENTRIES-1:0] fill_match;
    logic               fill_any;
    logic [IDX_W-1:0]   fill_hit_idx;
    logic [IDX_W-1:0]   victim_idx;
    logic               full;
    logic               fill_go;
    logic               replace;
    logic [IDX_W-1:0]   fill_idx;

    tlb_cam #(.N(ENTRIES), .KEY_W(VPN_W), .IDX_W(IDX_W)) u_fill_cam (
        .valid (vld_q),
        .tags  (tag_q),
        .key   (fill_vpn),
        .match (fill_match),
        .any   (fill_any),
        .idx   (fill_hit_idx)
    );

    assign fill_go  = fill_valid && !flush;
    assign replace  = fill_go && !fill_any && full;
    assign fill_idx = fill_any ? fill_hit_idx : victim_idx;

    tlb_victim #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (vld_q),
        .advance (replace),
        .idx     (victim_idx),
        .full    (full)
    );

    // Control bits of the entries
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q   <= '0;
            prs_q   <= '0;
            dirty_q <= '0;
        end else if (flush) begin
            vld_q   <= '0;
        end else begin
            if (lk_valid && lk_write && lk_any && prs_q[lk_idx]) begin
                dirty_q[lk_idx] <= 1'b1;
            end
            if (fill_go) begin
                vld_q[fill_idx]   <= 1'b1;
                prs_q[fill_idx]   <= fill_present;
                dirty_q[fill_idx] <= 1'b0;
            end
        end
    end

    // Tag and frame payload
    always_ff @(posedge clk) begin
        if (fill_go) begin
            tag_q[fill_idx] <= fill_vpn;
            frm_q[fill_idx] <= fill_ppn;
        end
    end

    // Eviction report
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evict_valid <= 1'b0;
            evict_vpn   <= '0;
            evict_ppn   <= '0;
            evict_dirty <= 1'b0;
        end else begin
            evict_valid <= replace;
            if (replace) begin
                evict_vpn   <= tag_q[victim_idx];
                evict_ppn   <= frm_q[victim_idx];
                evict_dirty <= dirty_q[victim_idx];
            end
        end
    end

    // Result state machine
    res_state_e state_q, state_d;
    logic [PA_W-1:0] paddr_q;

    always_comb begin
        if (!lk_valid)              state_d = RS_IDLE;
        else if (!lk_any)           state_d = RS_MISS;
        else if (prs_q[lk_idx])     state_d = RS_HIT;
        else                        state_d = RS_FAULT;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
            paddr_q <= '0;
        end else begin
            state_q <= state_d;
            paddr_q <= (state_d == RS_HIT)
                       ? {frm_q[lk_idx], lk_vaddr[OFF_W-1:0]} : '0;
        end
    end

    always_comb begin
        res_hit   = 1'b0;
        res_miss  = 1'b0;
        res_fault = 1'b0;
        unique case (state_q)
            RS_IDLE:  ;
            RS_HIT:   res_hit   = 1'b1;
            RS_MISS:  res_miss  = 1'b1;
            RS_FAULT: res_fault = 1'b1;
        endcase
    end

    assign res_paddr = paddr_q;

endmodule

// File: rtl/tlb_xlat_chk.sv
module tlb_xlat_chk #(
    parameter int VA_W  = 32,
    parameter int OFF_W = 12,
    parameter int PPN_W = 20
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   lk_valid,
    input logic [VA_W-1:0]        lk_vaddr,
    input logic                   fill_valid,
    input logic [VA_W-OFF_W-1:0]  fill_vpn,
    input logic                   flush,
    input logic                   res_hit,
    input logic                   res_miss,
    input logic                   res_fault,
    input logic [PPN_W+OFF_W-1:0] res_paddr,
    input logic                   evict_valid
);

    assert_offset_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> res_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0]));

    assert_nohit_zero_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (res_miss || res_fault) |-> res_paddr == '0);

    assert_one_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> $onehot({res_hit, res_miss, res_fault}));

    assert_quiet_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !(res_hit || res_miss || res_fault));

    assert_fill_visible_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !flush ##1 lk_valid && lk_vaddr[VA_W-1:OFF_W] == $past(fill_vpn))
        |=> !res_miss);

    assert_evict_after_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
        evict_valid |-> $past(fill_valid) && !$past(flush));

    assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flush ##1 lk_valid) |=> res_miss);

endmodule

bind tlb_xlat tlb_xlat_chk #(.VA_W(VA_W), .OFF_W(OFF_W), .PPN_W(PPN_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_valid    (lk_valid),
    .lk_vaddr    (lk_vaddr),
    .fill_valid  (fill_valid),
    .fill_vpn    (fill_vpn),
    .flush       (flush),
    .res_hit     (res_hit),
    .res_miss    (res_miss),
    .res_fault   (res_fault),
    .res_paddr   (res_paddr),
    .evict_valid (evict_valid)
);

// File: tb/sim_tlb_xlat.sv
module sim_tlb_xlat;

    localparam int CLK_PERIOD = 10;
    localparam int N = 16;

    // kind codes: 0 miss, 1 hit, 2 fault
    typedef struct packed {
        logic [31:0] va;
        logic        wr;
        logic [1:0]  kind;
        logic [31:0] pa;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{32'h00100ABC, 1'b0, 2'd1, 32'h00800ABC},
        '{32'h0010FFFF, 1'b1, 2'd1, 32'h0080FFFF},
        '{32'h00103123, 1'b1, 2'd2, 32'h00000000},
        '{32'h00200000, 1'b0, 2'd0, 32'h00000000},
        '{32'h00100000, 1'b1, 2'd1, 32'h00800000},
        '{32'hFFFFFFFF, 1'b0, 2'd0, 32'h00000000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0, lk_write = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        fill_valid = 1'b0, fill_present = 1'b0, flush = 1'b0;
    logic [19:0] fill_vpn = '0, fill_ppn = '0;
    logic        res_hit, res_miss, res_fault;
    logic [31:0] res_paddr;
    logic        evict_valid, evict_dirty;
    logic [19:0] evict_vpn, evict_ppn;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlb_xlat #(.ENTRIES(N)) u0 (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_write(lk_write),
        .lk_vaddr(lk_vaddr), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
        .fill_ppn(fill_ppn), .fill_present(fill_present), .flush(flush),
        .res_hit(res_hit), .res_miss(res_miss), .res_fault(res_fault),
        .res_paddr(res_paddr), .evict_valid(evict_valid), .evict_vpn(evict_vpn),
        .evict_ppn(evict_ppn), .evict_dirty(evict_dirty)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] kind_now();
        if ({res_hit, res_miss, res_fault} == 3'b100) return 2'd1;
        if ({res_hit, res_miss, res_fault} == 3'b010) return 2'd0;
        if ({res_hit, res_miss, res_fault} == 3'b001) return 2'd2;
        return 2'd3;
    endfunction

    task automatic look(input logic [31:0] va, input logic wr,
                        output logic [1:0] kind, output logic [31:0] pa);
        @(negedge clk);
        lk_valid = 1'b1; lk_write = wr; lk_vaddr = va;
        @(negedge clk);
        kind = kind_now(); pa = res_paddr;
        lk_valid = 1'b0; lk_write = 1'b0;
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn, input logic prs,
                        output logic ev, output logic [19:0] evpn,
                        output logic [19:0] eppn, output logic ed);
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = vpn; fill_ppn = ppn; fill_present = prs;
        @(negedge clk);
        ev = evict_valid; evpn = evict_vpn; eppn = evict_ppn; ed = evict_dirty;
        fill_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [1:0]  k;
        logic [31:0] pa;
        logic        ev, ed;
        logic [19:0] evpn, eppn;

        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 result flags", {res_hit, res_miss, res_fault}, 0);
        chk("R11 paddr", res_paddr, 0);
        chk("R11 evict", evict_valid, 0);
        rst_n = 1'b1;

        // R11: nothing valid after reset
        look(32'h00000123, 1'b0, k, pa);
        chk("R11 empty after reset miss", k, 0);

        // R6: fill all entries into free slots, entry 3 non-resident
        for (int i = 0; i < N; i++) begin
            fill(20'h00100 + 20'(i), 20'h00800 + 20'(i), (i != 3), ev, evpn, eppn, ed);
            chk("R6 free slot no evict", ev, 0);
        end

        // R1 R2 R3 R5: lookup table
        for (int v = 0; v < NV; v++) begin
            look(VEC[v].va, VEC[v].wr, k, pa);
            chk("R1/R2/R3 kind", k, VEC[v].kind);
            chk("R1/R2/R3 paddr", pa, VEC[v].pa);
        end

        // R4: no lookup gives no result
        @(negedge clk);
        chk("R4 idle flags", {res_hit, res_miss, res_fault}, 0);

        // R7 R8: rotation from entry 0 with modified flags
        fill(20'h00300, 20'h00900, 1'b1, ev, evpn, eppn, ed);
        chk("R7 evict valid e0", ev, 1);
        chk("R7 evict vpn e0", evpn, 20'h00100);
        chk("R7 evict ppn e0", eppn, 20'h00800);
        chk("R8 dirty after write hit", ed, 1);
        fill(20'h00301, 20'h00901, 1'b1, ev, evpn, eppn, ed);
        chk("R7 evict vpn e1", evpn, 20'h00101);
        chk("R8 clean entry", ed, 0);
        fill(20'h00302, 20'h00902, 1'b1, ev, evpn, eppn, ed);
        chk("R7 evict vpn e2", evpn, 20'h00102);
        fill(20'h00303, 20'h00903, 1'b1, ev, evpn, eppn, ed);
        chk("R7 evict vpn e3", evpn, 20'h00103);
        chk("R5 write on fault leaves clean", ed, 0);

        look(32'h00100000, 1'b0, k, pa);
        chk("R7 evicted page misses", k, 0);
        look(32'h00300456, 1'b0, k, pa);
        chk("R1 new page hits", k, 1);
        chk("R1 new page paddr", pa, 32'h00900456);

        // R9: overwrite in place (entry 15, modified earlier)
        fill(20'h0010F, 20'h00ABC, 1'b1, ev, evpn, eppn, ed);
        chk("R9 no evict on refill in place", ev, 0);
        look(32'h0010F123, 1'b0, k, pa);
        chk("R9 new frame", pa, 32'h00ABC123);
        for (int j = 0; j < 11; j++) begin
            fill(20'h00400 + 20'(j), 20'h00A00, 1'b1, ev, evpn, eppn, ed);
            chk("R7 rotation order", evpn, 20'h00104 + 20'(j));
        end
        fill(20'h0040B, 20'h00A00, 1'b1, ev, evpn, eppn, ed);
        chk("R7 wrap to entry 15", evpn, 20'h0010F);
        chk("R9 overwritten frame evicted", eppn, 20'h00ABC);
        chk("R9 flag cleared by overwrite", ed, 0);

        // R10: flush wins over simultaneous fill
        @(negedge clk);
        flush = 1'b1; fill_valid = 1'b1; fill_vpn = 20'h00555;
        fill_ppn = 20'h00555; fill_present = 1'b1;
        @(negedge clk);
        flush = 1'b0; fill_valid = 1'b0;
        look(32'h00555000, 1'b0, k, pa);
        chk("R10 fill during flush dropped", k, 0);
        look(32'h00300000, 1'b0, k, pa);
        chk("R10 flushed page misses", k, 0);
        fill(20'h00600, 20'h00777, 1'b1, ev, evpn, eppn, ed);
        chk("R6 free slot after flush", ev, 0);
        look(32'h00600FED, 1'b1, k, pa);
        chk("R1 hit after flush refill", pa, 32'h00777FED);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule